// File: doc/BRIEF.md
# TDM Serial Port Timeslot Assigner

This block finds where each channel sits in the frame of a serial data port that is synchronous to its frame. It runs on the port's data clock (up to 4096 kHz, so 512 bit times per 125 us frame). Each frame starts with an active-high sync pulse one data-clock period wide. After each sync pulse the block counts bit positions and compares them against programmed start positions for two 8-bit bearer channels and one 2-bit signalling channel. It drives a transmit-enable strobe and a receive-capture strobe for each channel. The data path that moves the channel bits uses these strobes.

The transmit and receive sides can run from one shared frame sync or from two independent syncs. A write-only register port sets the start positions and the sync mode. Start positions fall on 2-bit boundaries, which gives 256 possible starts. A new start value is held aside and takes effect at the next sync of its own direction, so a frame in progress is never disturbed.

Top module: `tdm_slot_assigner`

## Requirements
- R1: While `rst` is high and after it falls, all strobes are low, all start values and the mode register are zero, and both position counters are idle until a sync is sampled.
- R2: Sync inputs are sampled on the rising edge of `clk`. If a sync is sampled high at edge n, bit position 0 is the period that follows. The strobe for bit position p is high between edges n+p+1 and n+p+2, a fixed one-cycle output latency. Counting stops after position 511 and stays idle until the next sync. A sync that arrives before position 511 restarts the count at 0.
- R3: Register addresses 0, 1 and 2 hold the transmit starts of bearer channel A, bearer channel B and the signalling channel. Addresses 3, 4 and 5 hold the receive starts of the same channels. An 8-bit value v places the channel's first bit at position 2*v.
- R4: Strobe bit 0 is bearer A, bit 1 is bearer B and bit 2 is the signalling channel. A bearer window is 8 consecutive bit positions long and the signalling window is 2 long.
- R5: A start write takes effect at the next sync sampled for that direction. A write on the same edge as a sync waits for the sync after it.
- R6: Window bits that would fall past position 511 are dropped and do not wrap. For example, a bearer at start 255 is strobed for only two bits.
- R7: Address 6 is the mode register: bit 0 requests split syncs, bit 1 selects long-frame format and bit 2 selects master mode. Split operation is active only when bit 0 is 1 and bits 1 and 2 are both 0. The transmit count then follows `fs_tx` and the receive count follows `fs_rx`, with any phase between them.
- R8: When split operation is not active, including when it is requested together with long-frame or master mode, both counts follow `fs_tx`, `fs_rx` has no effect, and the two counts stay locked together.
- R9: Writes to address 7 have no effect. A mode-register write is applied from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tx | input | 1 | Transmit (or shared) frame sync pulse |
| fs_rx | input | 1 | Receive frame sync pulse, used only in split operation |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tx_en | output | 3 | Transmit-enable strobes, one per channel |
| rx_cap | output | 3 | Receive-capture strobes, one per channel |

## Verification
The bench places bearer windows at the end of the frame, at starts 253 and 255. A design that wrapped them would strobe bits at the frame start, and one that missed the last positions would give short counts. It rewrites a start in the middle of a frame and on the sync edge itself. A design that applied the value at once would move the window inside the running frame. It combines the split request with long-frame and master mode while pulsing `fs_rx` at an offset. A design that failed to force the shared sync would shift the receive strobes away from the transmit ones. Short frames and missing syncs check the restart and idle rules, which a design that wrapped its counter would break.

// File: rtl/tdm_ts_pkg.sv
package tdm_ts_pkg;

  localparam int unsigned N_CH = 3;

  typedef struct packed {
    logic master;
    logic long_frame;
    logic split;
  } ts_ctrl_t;

  function automatic int unsigned win_len(int unsigned ch, int unsigned b_len,
                                          int unsigned d_len);
    return (ch == N_CH - 1) ? d_len : b_len;
  endfunction

endpackage

// File: rtl/tdm_ts_regs.sv
module tdm_ts_regs
  import tdm_ts_pkg::*;
#(
  parameter int unsigned START_W = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [START_W-1:0]              wdata,
  output logic [N_CH-1:0][START_W-1:0]    tx_shadow,
  output logic [N_CH-1:0][START_W-1:0]    rx_shadow,
  output ts_ctrl_t                        ctrl
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * N_CH);

  for (genvar c = 0; c < N_CH; c++) begin : g_start
    always_ff @(posedge clk) begin
      if (rst) begin
        tx_shadow[c] <= '0;
        rx_shadow[c] <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(c))        tx_shadow[c] <= wdata;
        if (addr == ADDR_W'(N_CH + c)) rx_shadow[c] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              ctrl <= '0;
    else if (we && addr == CTRL_ADDR)     ctrl <= ts_ctrl_t'(wdata[2:0]);
  end

  // R9: the mode register moves only on a write to its own address
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == CTRL_ADDR) |=> $stable(ctrl));

endmodule

// File: rtl/tdm_ts_counter.sv
module tdm_ts_counter
  import tdm_ts_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 512,
  parameter int unsigned START_W    = 8,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync,
  input  logic [N_CH-1:0][START_W-1:0] shadow,
  output logic [POS_W-1:0]             pos,
  output logic                         run,
  output logic [N_CH-1:0][START_W-1:0] act
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      run <= 1'b0;
      act <= '0;
    end else if (sync) begin
      pos <= '0;
      run <= 1'b1;
      act <= shadow;
    end else if (run) begin
      if (pos == LAST) run <= 1'b0;
      else             pos <= pos + 1'b1;
    end
  end

  // R2: a sampled sync opens position zero on the next cycle
  a_r2_sync_restart: assert property (@(posedge clk) disable iff (rst)
    sync |=> (run && pos == '0));

  // R2: positions advance one per clock while running
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && !sync && pos != LAST) |=> (run && pos == $past(pos) + 1'b1));

  // R6: no wrap past the last bit of the frame
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !sync && pos == LAST) |=> !run);

  // R5: active starts change only at a sync
  a_r5_hold_active: assert property (@(posedge clk) disable iff (rst)
    !sync |=> $stable(act));

endmodule

// File: rtl/tdm_ts_window.sv
module tdm_ts_window #(
  parameter int unsigned FRAME_BITS = 512,
  parameter int unsigned START_W    = 8,
  parameter int unsigned LEN        = 8,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS),
  localparam int unsigned SB_W      = START_W + 1,
  localparam int unsigned CMP_W     = ((POS_W > SB_W) ? POS_W : SB_W) + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [POS_W-1:0]   pos,
  input  logic               run,
  input  logic [START_W-1:0] start,
  output logic               strobe
);

  logic [CMP_W-1:0] p_ext, s_ext, e_ext, f_ext;
  logic             hit;

  always_comb begin
    p_ext = CMP_W'(pos);
    s_ext = CMP_W'({start, 1'b0});
    e_ext = s_ext + CMP_W'(LEN);
    f_ext = CMP_W'(FRAME_BITS);
    hit   = run && (p_ext >= s_ext) && (p_ext < e_ext) && (p_ext < f_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= hit;
  end

  // R4: a strobe always follows a running position count
  a_r4_needs_run: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(run));

endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
  import tdm_ts_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 512,
  parameter int unsigned START_W    = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned B_LEN      = 8,
  parameter int unsigned D_LEN      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fs_tx,
  input  logic               fs_rx,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [START_W-1:0] cfg_wdata,
  output logic [N_CH-1:0]    tx_en,
  output logic [N_CH-1:0]    rx_cap
);

  localparam int unsigned POS_W = $clog2(FRAME_BITS);

  logic [N_CH-1:0][START_W-1:0] tx_shadow, rx_shadow, tx_act, rx_act;
  ts_ctrl_t                     ctrl;
  logic                         split_eff, rx_sync;
  logic [POS_W-1:0]             tx_pos, rx_pos;
  logic                         tx_run, rx_run;

  tdm_ts_regs #(.START_W(START_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tx_shadow(tx_shadow), .rx_shadow(rx_shadow), .ctrl(ctrl)
  );

  // split syncs are forbidden with long frames and locked in master mode
  assign split_eff = ctrl.split && !ctrl.long_frame && !ctrl.master;
  assign rx_sync   = split_eff ? fs_rx : fs_tx;

  tdm_ts_counter #(.FRAME_BITS(FRAME_BITS), .START_W(START_W)) u_tx_cnt (
    .clk(clk), .rst(rst), .sync(fs_tx), .shadow(tx_shadow),
    .pos(tx_pos), .run(tx_run), .act(tx_act)
  );

  tdm_ts_counter #(.FRAME_BITS(FRAME_BITS), .START_W(START_W)) u_rx_cnt (
    .clk(clk), .rst(rst), .sync(rx_sync), .shadow(rx_shadow),
    .pos(rx_pos), .run(rx_run), .act(rx_act)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    localparam int unsigned LEN = win_len(c, B_LEN, D_LEN);

    tdm_ts_window #(.FRAME_BITS(FRAME_BITS), .START_W(START_W), .LEN(LEN)) u_tx_win (
      .clk(clk), .rst(rst), .pos(tx_pos), .run(tx_run), .start(tx_act[c]),
      .strobe(tx_en[c])
    );

    tdm_ts_window #(.FRAME_BITS(FRAME_BITS), .START_W(START_W), .LEN(LEN)) u_rx_win (
      .clk(clk), .rst(rst), .pos(rx_pos), .run(rx_run), .start(rx_act[c]),
      .strobe(rx_cap[c])
    );
  end

  // R8: with a shared sync both counts move together
  a_r8_locked: assert property (@(posedge clk) disable iff (rst)
    (!split_eff && fs_tx) |=> (tx_pos == rx_pos && tx_run == rx_run));

  // R7: in split operation the receive count follows its own sync
  a_r7_rx_own_sync: assert property (@(posedge clk) disable iff (rst)
    (split_eff && fs_rx) |=> (rx_run && rx_pos == '0));

endmodule

// File: tb/tdm_slot_assigner_bench.sv
module tdm_slot_assigner_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fs_tx = 1'b0, fs_rx = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] tx_en, rx_cap;

  tdm_slot_assigner u_tdm_slot_assigner (
    .clk(clk), .rst(rst), .fs_tx(fs_tx), .fs_rx(fs_rx), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tx_en(tx_en), .rx_cap(rx_cap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference model
  int       tx_pos = -1, rx_pos = -1;
  int       tx_sh[3], rx_sh[3], tx_act[3], rx_act[3];
  bit [2:0] mode = 3'b000;
  bit [2:0] exp_tx = '0, exp_rx = '0;
  int       hi_tx[3], hi_rx[3];

  function automatic bit in_win(int pos, int st, int ch);
    int len = (ch == 2) ? 2 : 8;
    if (pos < 0) return 1'b0;
    return (pos >= st * 2) && (pos < st * 2 + len) && (pos < FRAME);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      tx_pos = -1; rx_pos = -1; mode = '0; exp_tx = '0; exp_rx = '0;
      for (int c = 0; c < 3; c++) begin
        tx_sh[c] = 0; rx_sh[c] = 0; tx_act[c] = 0; rx_act[c] = 0;
      end
    end else begin
      bit split, rs;
      for (int c = 0; c < 3; c++) begin
        exp_tx[c] = in_win(tx_pos, tx_act[c], c);
        exp_rx[c] = in_win(rx_pos, rx_act[c], c);
      end
      split = mode[0] && !mode[1] && !mode[2];
      rs    = split ? fs_rx : fs_tx;
      if (fs_tx) begin
        tx_pos = 0; for (int c = 0; c < 3; c++) tx_act[c] = tx_sh[c];
      end else if (tx_pos >= 0) tx_pos = (tx_pos == FRAME - 1) ? -1 : tx_pos + 1;
      if (rs) begin
        rx_pos = 0; for (int c = 0; c < 3; c++) rx_act[c] = rx_sh[c];
      end else if (rx_pos >= 0) rx_pos = (rx_pos == FRAME - 1) ? -1 : rx_pos + 1;
      if (cfg_we) begin
        if (cfg_addr < 3)        tx_sh[cfg_addr] = int'(cfg_wdata);
        else if (cfg_addr < 6)   rx_sh[cfg_addr - 3] = int'(cfg_wdata);
        else if (cfg_addr == 6)  mode = cfg_wdata[2:0];
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " tx_en"}, int'(tx_en), int'(exp_tx));
      check({cur_req, " rx_cap"}, int'(rx_cap), int'(exp_rx));
      for (int c = 0; c < 3; c++) begin
        if (tx_en[c])  hi_tx[c]++;
        if (rx_cap[c]) hi_rx[c]++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_hi();
    for (int c = 0; c < 3; c++) begin hi_tx[c] = 0; hi_rx[c] = 0; end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one frame of len cycles; fs_rx pulses at rx_off (negative: never)
  task automatic frame(int len, int rx_off);
    @(negedge clk);
    fs_tx = 1'b1; fs_rx = (rx_off == 0);
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      fs_tx = 1'b0; fs_rx = (i == rx_off);
    end
    @(negedge clk);
    fs_tx = 1'b0; fs_rx = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin hi_tx[c] = 0; hi_rx[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset tx_en", int'(tx_en), 0);
    check("R1 reset rx_cap", int'(rx_cap), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 idle after reset", int'({tx_en, rx_cap}), 0);

    // R3/R4: basic placement with shared sync
    cur_req = "R3";
    wr(0, 0); wr(1, 4); wr(2, 8); wr(3, 1); wr(4, 20); wr(5, 100);
    clear_hi();
    frame(520, -1);
    check("R4 B-A tx width", hi_tx[0], 8);
    check("R4 sig tx width", hi_tx[2], 2);
    check("R4 B-B rx width", hi_rx[1], 8);
    cur_req = "R2";
    frame(520, -1);

    // R6: windows at the frame end are cut, not wrapped
    cur_req = "R6";
    wr(0, 255); wr(1, 253); wr(2, 255);
    clear_hi();
    frame(520, -1);
    check("R6 B-A at 255", hi_tx[0], 2);
    check("R6 B-B at 253", hi_tx[1], 6);
    check("R6 sig at 255", hi_tx[2], 2);

    // R5: mid-frame write waits for the next sync
    cur_req = "R5";
    wr(0, 100);
    frame(520, -1);
    clear_hi();
    fork
      frame(520, -1);
      begin repeat (50) @(negedge clk); wr(0, 255); end
    join
    check("R5 mid-frame write deferred", hi_tx[0], 8);
    clear_hi();
    frame(520, -1);
    check("R5 write applied next frame", hi_tx[0], 2);
    // write on the sync edge itself
    @(negedge clk);
    fs_tx = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'd10;
    @(negedge clk);
    fs_tx = 1'b0; cfg_we = 1'b0;
    clear_hi();
    repeat (520) @(negedge clk);
    check("R5 sync-edge write deferred", hi_tx[0], 2);
    frame(520, -1);

    // R2: restart by early sync, and idle with no sync
    cur_req = "R2";
    wr(0, 0); wr(3, 140);
    frame(300, -1);
    frame(300, -1);
    repeat (600) @(negedge clk);
    check("R2 idle without sync", int'({tx_en, rx_cap}), 0);

    // R7: independent receive sync at an offset
    cur_req = "R7";
    wr(6, 1);
    frame(520, 100);
    frame(520, 333);
    frame(520, 0);

    // R8: split with long-frame or master is forced shared
    cur_req = "R8";
    wr(3, 0); wr(4, 4); wr(5, 255);
    wr(0, 0); wr(1, 4); wr(2, 255);
    wr(6, 3);
    frame(520, -1);
    clear_hi();
    frame(520, 77);
    check("R8 long-frame rx = tx count", hi_rx[1], hi_tx[1]);
    wr(6, 5);
    frame(520, 201);
    wr(6, 7);
    frame(520, 45);

    // R9: address 7 writes have no effect
    cur_req = "R9";
    wr(6, 0);
    wr(7, 8'hFF);
    frame(520, 150);
    clear_hi();
    frame(520, 60);
    check("R9 addr 7 ignored sig rx", hi_rx[2], 2);
    wr(6, 1);
    frame(520, 60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule